// File: doc/BRIEF.md
# Masked Vector Lane Writeback Unit

This unit forms the value written back to a 512-bit vector destination after a lane-wise operation. It takes the new per-lane 32-bit results, the current destination contents and a per-lane write mask. It returns the full 512-bit word to store. Lanes selected by the mask, or all lanes when masking is switched off, take the new result. Unselected lanes either keep the old destination value (merge mode) or are written with zero (zero mode).

A two-bit vector-length select sets how many lanes are active: 4, 8 or 16 lanes of 32 bits. Every bit above the active length is cleared, whatever the mask, the mode or the old contents. A broadcast flag makes each written lane take element 0 of the result vector instead of its own element. The unit does not compute the lane results. By default it has one output register with a synchronous active-high reset. A parameter can remove the register and leave a purely combinational path.

Top module: `mvwb_unit`

## Requirements
- R1: The vector-length select `vlen_i` encodes 2'b00 as 4 active lanes, 2'b01 as 8 and both 2'b10 and 2'b11 as 16; lane j occupies bits [32j+31:32j] of every data vector.
- R2: An active lane whose `mask_i` bit j is 1 is written with its new result.
- R3: When `mask_off_i` is 1, every active lane is written with its new result regardless of `mask_i`.
- R4: With `zero_mode_i` = 0 (merge), an active lane whose mask bit is 0 and with masking enabled keeps its value from `old_i`.
- R5: With `zero_mode_i` = 1 (zero), an active lane whose mask bit is 0 and with masking enabled is written with 32'h0.
- R6: When `bcast_i` is 1, every active lane that is written with a new result receives element 0 (bits [31:0]) of `res_i`.
- R7: All output bits from the active vector length up to bit 511 are zero.
- R8: Mask bits at positions at or above the active lane count have no effect on the output.
- R9: With the default output register, `wb_o` shows the result for the inputs present at a rising clock edge from that edge onward; a synchronous reset (`rst` = 1 at an edge) drives `wb_o` to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_i | input | 512 | New per-lane results, lane j at [32j+31:32j] |
| old_i | input | 512 | Current destination contents |
| mask_i | input | 16 | Per-lane write mask |
| mask_off_i | input | 1 | 1 = write every active lane, ignore the mask |
| zero_mode_i | input | 1 | 0 = merge unselected lanes, 1 = zero them |
| vlen_i | input | 2 | Active length: 00 = 4 lanes, 01 = 8, 10/11 = 16 |
| bcast_i | input | 1 | 1 = every written lane takes element 0 |
| wb_o | output | 512 | Value to write back |

## Verification
Broadcast, zero filling and clearing above the active length all act on the same output word in the same cycle. This happens whenever `bcast_i` and `zero_mode_i` are set together with a short vector length and a partial mask. The bench reaches this case by stepping through every combination of length, mode and broadcast with random masks and data, both with masking enabled and with it disabled. It compares all 512 output bits with a lane-by-lane model. Each lane must show, at the same moment, element 0, zero or old data as its mask bit dictates, with zeros above the active length.

// File: rtl/mvwb_pkg.sv
package mvwb_pkg;
  localparam int unsigned VLEN_W = 2;

  function automatic int unsigned active_lanes(input logic [VLEN_W-1:0] sel,
                                               input int unsigned max_lanes);
    case (sel)
      2'd0:    return max_lanes / 4;
      2'd1:    return max_lanes / 2;
      default: return max_lanes;
    endcase
  endfunction
endpackage

// File: rtl/mvwb_lane_enable.sv
module mvwb_lane_enable
  import mvwb_pkg::*;
#(
  parameter int unsigned LANES = 16
) (
  input  logic [VLEN_W-1:0] vlen,
  input  logic [LANES-1:0]  mask,
  input  logic              mask_off,
  output logic [LANES-1:0]  active,
  output logic [LANES-1:0]  write_en
);
  localparam int unsigned CW = $clog2(LANES + 1);

  logic [CW-1:0] lane_cnt;

  always_comb lane_cnt = CW'(active_lanes(vlen, LANES));

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      active[j]   = (CW'(j) < lane_cnt);
      write_en[j] = active[j] & (mask_off | mask[j]);
    end
  end
endmodule

// File: rtl/mvwb_lane_source.sv
module mvwb_lane_source #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned LANE_W = 32
) (
  input  logic [LANES*LANE_W-1:0] res,
  input  logic                    bcast,
  output logic [LANES*LANE_W-1:0] src
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb src[j*LANE_W +: LANE_W] = bcast ? res[LANE_W-1:0]
                                                : res[j*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/mvwb_lane_merge.sv
module mvwb_lane_merge #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned LANE_W = 32
) (
  input  logic [LANES*LANE_W-1:0] src,
  input  logic [LANES*LANE_W-1:0] old,
  input  logic [LANES-1:0]        active,
  input  logic [LANES-1:0]        write_en,
  input  logic                    zero_mode,
  output logic [LANES*LANE_W-1:0] nxt
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      if (!active[j])
        nxt[j*LANE_W +: LANE_W] = '0;
      else if (write_en[j])
        nxt[j*LANE_W +: LANE_W] = src[j*LANE_W +: LANE_W];
      else if (zero_mode)
        nxt[j*LANE_W +: LANE_W] = '0;
      else
        nxt[j*LANE_W +: LANE_W] = old[j*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/mvwb_unit.sv
module mvwb_unit
  import mvwb_pkg::*;
#(
  parameter int unsigned LANES   = 16,
  parameter int unsigned LANE_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*LANE_W-1:0] res_i,
  input  logic [LANES*LANE_W-1:0] old_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic                    mask_off_i,
  input  logic                    zero_mode_i,
  input  logic [VLEN_W-1:0]       vlen_i,
  input  logic                    bcast_i,
  output logic [LANES*LANE_W-1:0] wb_o
);
  localparam int unsigned DW = LANES * LANE_W;
  localparam int unsigned CW = $clog2(LANES + 1);

  logic [LANES-1:0] active, write_en;
  logic [DW-1:0]    src, nxt;

  mvwb_lane_enable #(.LANES(LANES)) i_enable (
    .vlen(vlen_i), .mask(mask_i), .mask_off(mask_off_i),
    .active(active), .write_en(write_en)
  );

  mvwb_lane_source #(.LANES(LANES), .LANE_W(LANE_W)) i_source (
    .res(res_i), .bcast(bcast_i), .src(src)
  );

  mvwb_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) i_merge (
    .src(src), .old(old_i), .active(active), .write_en(write_en),
    .zero_mode(zero_mode_i), .nxt(nxt)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) wb_o <= '0;
      else     wb_o <= nxt;
    end

    p_reset_clear_r9: assert property (@(posedge clk) rst |=> (wb_o == '0));
    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (wb_o == $past(nxt)));
  end else begin : g_comb
    always_comb wb_o = nxt;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_chk
    logic in_len;
    always_comb in_len = (CW'(j) < CW'(active_lanes(vlen_i, LANES)));

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
      !in_len |-> (nxt[j*LANE_W +: LANE_W] == '0));
    p_write_new_r2: assert property (@(posedge clk) disable iff (rst)
      (in_len && (mask_i[j] || mask_off_i)) |->
        (nxt[j*LANE_W +: LANE_W] == (bcast_i ? res_i[LANE_W-1:0]
                                             : res_i[j*LANE_W +: LANE_W])));
    p_merge_keep_r4: assert property (@(posedge clk) disable iff (rst)
      (in_len && !mask_i[j] && !mask_off_i && !zero_mode_i) |->
        (nxt[j*LANE_W +: LANE_W] == old_i[j*LANE_W +: LANE_W]));
    p_zero_fill_r5: assert property (@(posedge clk) disable iff (rst)
      (in_len && !mask_i[j] && !mask_off_i && zero_mode_i) |->
        (nxt[j*LANE_W +: LANE_W] == '0));
  end
endmodule

// File: tb/test_mvwb_unit.sv
module test_mvwb_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [511:0] res_i, old_i, wb_o;
  logic [15:0]  mask_i;
  logic         mask_off_i, zero_mode_i, bcast_i;
  logic [1:0]   vlen_i;

  int checks = 0;
  int fails  = 0;

  // control table: {vlen[1:0], zero_mode, bcast}
  localparam logic [3:0] CTRL [12] = '{
    4'b00_0_0, 4'b00_0_1, 4'b00_1_0, 4'b00_1_1,
    4'b01_0_0, 4'b01_0_1, 4'b01_1_0, 4'b01_1_1,
    4'b10_0_0, 4'b10_0_1, 4'b10_1_0, 4'b10_1_1
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  mvwb_unit i_mvwb_unit (
    .clk(clk), .rst(rst), .res_i(res_i), .old_i(old_i), .mask_i(mask_i),
    .mask_off_i(mask_off_i), .zero_mode_i(zero_mode_i), .vlen_i(vlen_i),
    .bcast_i(bcast_i), .wb_o(wb_o)
  );

  function automatic logic [511:0] model(
    input logic [511:0] r, input logic [511:0] o, input logic [15:0] m,
    input logic moff, input logic zm, input logic [1:0] vl, input logic bc);
    logic [511:0] e;
    int n;
    n = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
    e = '0;
    for (int j = 0; j < 16; j++) begin
      if (j < n) begin
        if (moff || m[j]) e[j*32 +: 32] = bc ? r[31:0] : r[j*32 +: 32];
        else if (zm)      e[j*32 +: 32] = 32'h0;
        else              e[j*32 +: 32] = o[j*32 +: 32];
      end
    end
    return e;
  endfunction

  function automatic logic [511:0] rand512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string tag, input logic [511:0] exp_v);
    checks++;
    if (wb_o !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, wb_o, exp_v);
    end
  endtask

  task automatic apply(input logic [511:0] r, input logic [511:0] o,
                       input logic [15:0] m, input logic moff, input logic zm,
                       input logic [1:0] vl, input logic bc);
    @(negedge clk);
    res_i = r; old_i = o; mask_i = m; mask_off_i = moff;
    zero_mode_i = zm; vlen_i = vl; bcast_i = bc;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [511:0] r, o;
    logic [15:0]  m;
    rst = 1'b1;
    res_i = '1; old_i = '1; mask_i = '1; mask_off_i = 1'b1;
    zero_mode_i = 1'b0; vlen_i = 2'd2; bcast_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 reset state", '0);
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 across all combinations
    for (int pass = 0; pass < 2; pass++) begin
      for (int t = 0; t < 12; t++) begin
        for (int d = 0; d < 3; d++) begin
          r = rand512(); o = rand512(); m = 16'($urandom);
          apply(r, o, m, pass[0], CTRL[t][1], CTRL[t][3:2], CTRL[t][0]);
          check("R1 R2 R3 R4 R5 R6 R7 R8 table",
                model(r, o, m, pass[0], CTRL[t][1], CTRL[t][3:2], CTRL[t][0]));
        end
      end
    end

    // R8: upper mask bits set, 4 lanes, merge: lanes keep old, upper cleared
    r = rand512(); o = rand512();
    apply(r, o, 16'hFFF0, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R8 upper mask ignored", {384'h0, o[127:0]});

    // R1: code 3 behaves as 16 lanes
    apply(r, o, 16'hFFFF, 1'b0, 1'b0, 2'd3, 1'b0);
    check("R1 code 3 full length", r);

    // R3: masking disabled with all-zero mask in zero mode
    apply(r, o, 16'h0000, 1'b1, 1'b1, 2'd1, 1'b0);
    check("R3 mask off", {256'h0, r[255:0]});

    // R5 + R7: all masked off in zero mode gives all zeros
    apply(r, o, 16'h0000, 1'b0, 1'b1, 2'd2, 1'b1);
    check("R5 all zeroed", '0);

    // R6: broadcast with full mask, 8 lanes
    apply(r, o, 16'h00FF, 1'b0, 1'b0, 2'd1, 1'b1);
    check("R6 broadcast", {256'h0, {8{r[31:0]}}});

    // R9: register holds one-cycle latency, then reset clears
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 sync reset", '0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule